// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the standard configuration header of a PCI target function. A host-side configuration engine presents a dword index, byte enables and write data. The block answers reads combinationally and applies writes on the next rising clock edge. Identity fields such as vendor, device, class code, subsystem, status, header type, capability pointer and interrupt pin are parameters and read-only. The command register, latency timer, cache-line size and interrupt line can be written.

Six base address registers and the expansion ROM base register follow the usual size-probe rules. An all-ones write makes the register read back the size mask it was built with. Ordinary writes are masked to the decodable address bits, and the type bits are forced from the build-time mask. A partial write first merges its bytes into the dword as it currently reads, then applies the same full-dword rules. Downstream address decoders get the live BAR values, the ROM base and enable, the command register, and a one-cycle change strobe for each BAR.

Top module: `pci_cfg_header`

## Requirements
- R1: After a synchronous active-low reset the following read as zero: the command register, all six BARs, the ROM BAR, latency timer, cache-line size and interrupt line. The change strobe is zero.
- R2: Reads are combinational on the dword index. The layout is:
  - index 0: {device, vendor}
  - index 1: {status, command}
  - index 2: class/revision
  - index 3: {BIST = 0, header type, latency timer, cache-line size}
  - indices 4..9: BAR0..BAR5
  - index 11: {subsystem id, subsystem vendor}
  - index 12: ROM BAR
  - index 13: capability pointer in bits 7:0
  - index 15: {max latency, min grant, interrupt pin, interrupt line}
- R3: A resulting dword of 0xFFFFFFFF written to an implemented BAR loads that BAR's configured size mask.
- R4: Any other write to an I/O BAR (mask bit 0 = 1) stores data AND 0xFFFFFFFC with bit 0 set.
- R5: Any other write to a memory BAR (mask bit 0 = 0, bits 2:1 = 0) stores data AND 0xFFFFFFF0 with bits 3:0 copied from the mask.
- R6: A BAR whose mask is zero, or whose mask is memory with bits 2:1 nonzero, is unimplemented. It always reads 0 and never strobes.
- R7: At index 12, a resulting dword of 0xFFFFF800 loads the ROM size mask. Any other write stores data AND 0xFFFFF801. The outputs are the ROM base (bits 31:11) and the ROM enable (bit 0).
- R8: A write with byte enables (bit n covers bits 8n+7:8n) merges the enabled bytes into the current read value before the R3..R7 rules apply. Writing single 0xFF bytes one at a time therefore never probes.
- R9: Writes leave these fields unchanged: status, BIST, header type, identity, class, subsystem, capability pointer, interrupt pin, min grant and max latency. These are writable: command (bits 15:0 at index 1), latency timer (bits 15:8 at index 3), cache-line size (bits 7:0 at index 3) and interrupt line (bits 7:0 at index 15).
- R10: Indices 10, 14 and 16..63 read as 0, and writes to them change nothing.
- R11: A write to implemented BAR k that is not a probe raises bit k of the change strobe for exactly the following cycle. Probe writes raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_addr | input | 6 | Dword index into the header |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| cmd_reg | output | 16 | Current command register |
| bar_flat | output | 192 | BAR0..BAR5 values, BAR k in bits 32k+31:32k |
| bar_changed | output | 6 | One-cycle strobe per BAR after a value write |
| rom_base | output | 21 | ROM base address bits 31:11 |
| rom_enable | output | 1 | ROM decode enable |

## Verification
The bench sweeps every one of the 64 dword indices after each write. Its model distinguishes I/O, memory and unimplemented BARs, so a design that forced the wrong low bits or let a 64-bit-typed BAR hold a value shows up at once. Byte-by-byte all-ones writes target the merge rule: a design that probed on each byte, or merged against stale data, would read back the size mask instead of the masked address. The near-miss ROM values 0xFFFFFFFF and 0xFFFFF800 catch a probe compare done on the wrong constant. Writes to read-only and unimplemented indices check that identity fields, status and BIST never move.

// File: rtl/pcicfg_pkg.sv
// Shared constants, BAR classification and byte-merge helper for the
// configuration header. Assumes 32-bit dwords and a 6-bit dword index.
package pcicfg_pkg;

    localparam int NUM_BARS  = 6;
    localparam int DW        = 32;
    localparam int IDX_W     = 6;
    localparam int ROM_LSB   = 11;
    localparam int ROM_BASE_W = DW - ROM_LSB;

    localparam logic [IDX_W-1:0] IDX_ID     = 6'd0;
    localparam logic [IDX_W-1:0] IDX_STACMD = 6'd1;
    localparam logic [IDX_W-1:0] IDX_CLASS  = 6'd2;
    localparam logic [IDX_W-1:0] IDX_TIMING = 6'd3;
    localparam logic [IDX_W-1:0] IDX_BAR0   = 6'd4;
    localparam logic [IDX_W-1:0] IDX_SUBSYS = 6'd11;
    localparam logic [IDX_W-1:0] IDX_ROM    = 6'd12;
    localparam logic [IDX_W-1:0] IDX_CAP    = 6'd13;
    localparam logic [IDX_W-1:0] IDX_INTR   = 6'd15;

    localparam logic [DW-1:0] BAR_PROBE = 32'hFFFF_FFFF;
    localparam logic [DW-1:0] ROM_PROBE = 32'hFFFF_F800;
    localparam logic [DW-1:0] ROM_KEEP  = 32'hFFFF_F801;
    localparam logic [DW-1:0] IO_KEEP   = 32'hFFFF_FFFC;
    localparam logic [DW-1:0] MEM_KEEP  = 32'hFFFF_FFF0;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_IO   = 2'd1,
        KIND_MEM  = 2'd2
    } bar_kind_e;

    // Decide what a BAR is from its build-time size mask.
    function automatic bar_kind_e classify(input logic [DW-1:0] mask);
        if (mask == '0)            return KIND_NONE;
        else if (mask[0])          return KIND_IO;
        else if (mask[2:1] != '0)  return KIND_NONE;
        else                       return KIND_MEM;
    endfunction

    // Replace the enabled bytes of cur with those of wd.
    function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] cur,
                                                  input logic [DW-1:0] wd,
                                                  input logic [3:0]    be);
        logic [DW-1:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = be[b] ? wd[8*b +: 8] : cur[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pcicfg_bar_slot.sv
// One base address register. Holds the value a host programmed, answers
// the all-ones size probe with SIZE_MASK, forces type bits on ordinary
// writes and strobes 'changed' for one cycle after a value write.
// Assumes wr_dword is the already byte-merged dword.
module pcicfg_bar_slot
    import pcicfg_pkg::*;
#(
    parameter logic [31:0] SIZE_MASK = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_dword,
    output logic [DW-1:0] value,
    output logic          changed
);

    localparam bar_kind_e KIND = classify(SIZE_MASK);

    logic is_probe;
    assign is_probe = (wr_dword == BAR_PROBE);

    // Value register: probe loads the mask, otherwise masked store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (KIND == KIND_NONE) begin
            value <= '0;
        end else if (wr_en) begin
            if (is_probe)
                value <= SIZE_MASK;
            else if (KIND == KIND_IO)
                value <= (wr_dword & IO_KEEP) | 32'h1;
            else
                value <= (wr_dword & MEM_KEEP) | {28'h0, SIZE_MASK[3:0]};
        end
    end

    // Change strobe: one cycle after a non-probe write to a live BAR.
    always_ff @(posedge clk) begin
        if (!rst_n)
            changed <= 1'b0;
        else
            changed <= wr_en && !is_probe && (KIND != KIND_NONE);
    end

endmodule

// File: rtl/pcicfg_rom_bar.sv
// Expansion ROM base register. The ROM size probe loads ROM_MASK; other
// writes keep the base bits and the enable bit. Assumes merged input.
module pcicfg_rom_bar
    import pcicfg_pkg::*;
#(
    parameter logic [31:0] ROM_MASK = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_dword,
    output logic [DW-1:0] value
);

    // ROM register update on probe or ordinary write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (wr_en)
            value <= (wr_dword == ROM_PROBE) ? ROM_MASK : (wr_dword & ROM_KEEP);
    end

endmodule

// File: rtl/pcicfg_ctl_regs.sv
// Writable control fields: command, latency timer, cache-line size and
// interrupt line. Each write enable selects one dword; wd is its low half.
module pcicfg_ctl_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_cmd,
    input  logic        wr_timing,
    input  logic        wr_intr,
    input  logic [15:0] wd,
    output logic [15:0] cmd,
    output logic [7:0]  lat_timer,
    output logic [7:0]  line_size,
    output logic [7:0]  int_line
);

    // Command register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd <= '0;
        else if (wr_cmd) cmd <= wd;
    end

    // Latency timer and cache-line size share one dword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_timer <= '0;
            line_size <= '0;
        end else if (wr_timing) begin
            lat_timer <= wd[15:8];
            line_size <= wd[7:0];
        end
    end

    // Interrupt line routing byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       int_line <= '0;
        else if (wr_intr) int_line <= wd[7:0];
    end

endmodule

// File: rtl/pci_cfg_header.sv
// Type-0 configuration header. Decodes the dword index, builds the
// combinational read word, merges byte-enabled writes against it and
// routes the merged dword to the BAR slots, ROM BAR and control fields.
// Assumes one write per cfg_wr cycle; reads need no strobe.
module pci_cfg_header
    import pcicfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1B2C,
    parameter logic [15:0] DEVICE_ID   = 16'h7E41,
    parameter logic [31:0] CLASS_REV   = 32'h0C03_3012,
    parameter logic [7:0]  HDR_TYPE    = 8'h00,
    parameter logic [15:0] STATUS_BITS = 16'h0210,
    parameter logic [15:0] SUB_VENDOR  = 16'h1B2C,
    parameter logic [15:0] SUB_ID      = 16'h0042,
    parameter logic [7:0]  CAP_PTR     = 8'h40,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [7:0]  MIN_GNT     = 8'h08,
    parameter logic [7:0]  MAX_LAT     = 8'h10,
    parameter logic [6*32-1:0] BAR_MASKS = {32'hFFFF_FFF1, 32'hFFFF_0004,
                                            32'h0000_0000, 32'hFFF0_0000,
                                            32'hFFFF_FF01, 32'hFFFF_F008},
    parameter logic [31:0] ROM_MASK    = 32'hFFFF_8000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [5:0]            cfg_addr,
    input  logic [3:0]            cfg_be,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    output logic [15:0]           cmd_reg,
    output logic [6*32-1:0]       bar_flat,
    output logic [5:0]            bar_changed,
    output logic [20:0]           rom_base,
    output logic                  rom_enable
);

    logic [DW-1:0] bar_val [NUM_BARS];
    logic [DW-1:0] rom_val;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] merged;
    logic [7:0]    lat_timer, line_size, int_line;

    // Read multiplexer over the header layout.
    always_comb begin
        rd_word = '0;
        case (cfg_addr)
            IDX_ID:     rd_word = {DEVICE_ID, VENDOR_ID};
            IDX_STACMD: rd_word = {STATUS_BITS, cmd_reg};
            IDX_CLASS:  rd_word = CLASS_REV;
            IDX_TIMING: rd_word = {8'h00, HDR_TYPE, lat_timer, line_size};
            IDX_SUBSYS: rd_word = {SUB_ID, SUB_VENDOR};
            IDX_ROM:    rd_word = rom_val;
            IDX_CAP:    rd_word = {24'h0, CAP_PTR};
            IDX_INTR:   rd_word = {MAX_LAT, MIN_GNT, INT_PIN, int_line};
            default: begin
                for (int i = 0; i < NUM_BARS; i++) begin
                    if (cfg_addr == IDX_BAR0 + IDX_W'(i))
                        rd_word = bar_val[i];
                end
            end
        endcase
    end

    assign cfg_rdata = rd_word;

    // Byte-enable merge against the dword as it currently reads.
    assign merged = merge_bytes(rd_word, cfg_wdata, cfg_be);

    genvar k;
    generate
        for (k = 0; k < NUM_BARS; k++) begin : g_bar
            logic hit;
            assign hit = cfg_wr && (cfg_addr == IDX_BAR0 + IDX_W'(k));
            pcicfg_bar_slot #(
                .SIZE_MASK (BAR_MASKS[32*k +: 32])
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (hit),
                .wr_dword (merged),
                .value    (bar_val[k]),
                .changed  (bar_changed[k])
            );
            assign bar_flat[32*k +: 32] = bar_val[k];
        end
    endgenerate

    pcicfg_rom_bar #(
        .ROM_MASK (ROM_MASK)
    ) u_rom (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr && (cfg_addr == IDX_ROM)),
        .wr_dword (merged),
        .value    (rom_val)
    );

    pcicfg_ctl_regs u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (cfg_wr && (cfg_addr == IDX_STACMD)),
        .wr_timing (cfg_wr && (cfg_addr == IDX_TIMING)),
        .wr_intr   (cfg_wr && (cfg_addr == IDX_INTR)),
        .wd        (merged[15:0]),
        .cmd       (cmd_reg),
        .lat_timer (lat_timer),
        .line_size (line_size),
        .int_line  (int_line)
    );

    assign rom_base   = rom_val[DW-1:ROM_LSB];
    assign rom_enable = rom_val[0];

endmodule

// File: rtl/pci_cfg_header_chk.sv
// Property checker for the configuration header, bound to every instance.
module pci_cfg_header_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [5:0]  cfg_addr,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [15:0] cmd_reg,
    input logic [5:0]  bar_changed,
    input logic [20:0] rom_base,
    input logic        rom_enable
);

    // A single write touches at most one BAR strobe.
    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bar_changed));

    // No write, no strobe in the next cycle.
    assert_strobe_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> (bar_changed == 6'h0));

    // An all-ones full-dword write is a probe and never strobes.
    assert_probe_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_be == 4'hF && cfg_wdata == 32'hFFFF_FFFF) |=> (bar_changed == 6'h0));

    // Command holds unless its low half is written.
    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_addr == 6'd1 && cfg_be[1:0] != 2'b00) |=> $stable(cmd_reg));

    // Ordinary full ROM write lands base and enable bits.
    assert_rom_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == 6'd12 && cfg_be == 4'hF && cfg_wdata != 32'hFFFF_F800)
        |=> (rom_enable == $past(cfg_wdata[0]) && rom_base == $past(cfg_wdata[31:11])));

    // Unimplemented indices read zero.
    assert_hole_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'd10 || cfg_addr == 6'd14 || cfg_addr >= 6'd16) |-> (cfg_rdata == 32'h0));

endmodule

bind pci_cfg_header pci_cfg_header_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .cfg_be      (cfg_be),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .cmd_reg     (cmd_reg),
    .bar_changed (bar_changed),
    .rom_base    (rom_base),
    .rom_enable  (rom_enable)
);

// File: tb/pci_cfg_header_tb.sv
// Sweeping bench: every write is followed by a read of all 64 indices,
// compared against an arithmetic model of the requirements.
module pci_cfg_header_tb;

    localparam logic [15:0] VEN = 16'h1B2C, DEV = 16'h7E41, STAT = 16'h0210;
    localparam logic [15:0] SVEN = 16'h1B2C, SID = 16'h0042;
    localparam logic [31:0] CREV = 32'h0C03_3012;
    localparam logic [7:0]  HDR = 8'h00, CAP = 8'h40, IPIN = 8'h01, MING = 8'h08, MAXL = 8'h10;
    localparam logic [31:0] MASK [6] = '{32'hFFFF_F008, 32'hFFFF_FF01, 32'hFFF0_0000,
                                        32'h0000_0000, 32'hFFFF_0004, 32'hFFFF_FFF1};
    localparam logic [31:0] RMASK = 32'hFFFF_8000;

    logic clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [3:0] cfg_be = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic [15:0] cmd_reg;
    logic [191:0] bar_flat;
    logic [5:0] bar_changed;
    logic [20:0] rom_base;
    logic rom_enable;

    always #5 clk = ~clk;

    pci_cfg_header #(
        .VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_REV(CREV), .HDR_TYPE(HDR),
        .STATUS_BITS(STAT), .SUB_VENDOR(SVEN), .SUB_ID(SID), .CAP_PTR(CAP),
        .INT_PIN(IPIN), .MIN_GNT(MING), .MAX_LAT(MAXL),
        .BAR_MASKS({MASK[5], MASK[4], MASK[3], MASK[2], MASK[1], MASK[0]}),
        .ROM_MASK(RMASK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_reg(cmd_reg), .bar_flat(bar_flat), .bar_changed(bar_changed),
        .rom_base(rom_base), .rom_enable(rom_enable)
    );

    int nvec = 0, nbad = 0;
    bit finished = 1'b0;

    // Model state.
    logic [31:0] m_bar [6];
    logic [31:0] m_rom;
    logic [15:0] m_cmd;
    logic [7:0]  m_lat, m_cls, m_il;
    logic [5:0]  m_chg;

    // 0 = unimplemented, 1 = I/O, 2 = memory.
    function automatic int kind(input logic [31:0] m);
        if (m == 0) return 0;
        if (m[0]) return 1;
        if (m[2:1] != 0) return 0;
        return 2;
    endfunction

    function automatic logic [31:0] mread(input int a);
        case (a)
            0: return {DEV, VEN};
            1: return {STAT, m_cmd};
            2: return CREV;
            3: return {8'h00, HDR, m_lat, m_cls};
            4, 5, 6, 7, 8, 9: return m_bar[a-4];
            11: return {SID, SVEN};
            12: return m_rom;
            13: return {24'h0, CAP};
            15: return {MAXL, MING, IPIN, m_il};
            default: return 32'h0;
        endcase
    endfunction

    task automatic mreset();
        for (int i = 0; i < 6; i++) m_bar[i] = '0;
        m_rom = '0; m_cmd = '0; m_lat = '0; m_cls = '0; m_il = '0; m_chg = '0;
    endtask

    task automatic mwrite(input int a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] cur, mg;
        cur = mread(a);
        for (int b = 0; b < 4; b++) mg[8*b +: 8] = be[b] ? d[8*b +: 8] : cur[8*b +: 8];
        m_chg = '0;
        case (a)
            1: m_cmd = mg[15:0];
            3: begin m_lat = mg[15:8]; m_cls = mg[7:0]; end
            15: m_il = mg[7:0];
            12: m_rom = (mg == 32'hFFFF_F800) ? RMASK : (mg & 32'hFFFF_F801);
            4, 5, 6, 7, 8, 9: begin
                if (kind(MASK[a-4]) != 0) begin
                    if (mg == 32'hFFFF_FFFF) m_bar[a-4] = MASK[a-4];
                    else begin
                        m_chg[a-4] = 1'b1;
                        if (kind(MASK[a-4]) == 1) m_bar[a-4] = (mg & 32'hFFFF_FFFC) | 32'h1;
                        else m_bar[a-4] = (mg & 32'hFFFF_FFF0) | {28'h0, MASK[a-4][3:0]};
                    end
                end
            end
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int a);
        if (a >= 4 && a <= 9) return (kind(MASK[a-4]) == 0) ? "R6" :
                                     (kind(MASK[a-4]) == 1) ? "R4" : "R5";
        if (a == 12) return "R7";
        if (a == 10 || a == 14 || a >= 16) return "R10";
        return "R2";
    endfunction

    // Full sweep of every index plus the side outputs.
    task automatic sweep(input string ctx);
        for (int a = 0; a < 64; a++) begin
            cfg_addr = 6'(a);
            #1;
            chk({tag_of(a), " ", ctx, $sformatf(" idx=%0d", a)}, cfg_rdata, mread(a));
        end
        for (int i = 0; i < 6; i++) chk({"R2 bar_flat ", ctx}, bar_flat[32*i +: 32], m_bar[i]);
        chk({"R7 rom outputs ", ctx}, {10'h0, rom_base, rom_enable}, {10'h0, m_rom[31:11], m_rom[0]});
        chk({"R9 cmd_reg ", ctx}, {16'h0, cmd_reg}, {16'h0, m_cmd});
    endtask

    task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 6'(a); cfg_be = be; cfg_wdata = d;
        mwrite(a, be, d);
        @(negedge clk);
        cfg_wr = 1'b0;
        chk($sformatf("R11 strobe after idx=%0d", a), {26'h0, bar_changed}, {26'h0, m_chg});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mreset();
        chk("R1 strobe at reset", {26'h0, bar_changed}, 32'h0);
        sweep("R1 after reset");
    endtask

    initial begin
        logic [31:0] pats [5];
        pats = '{32'h0000_0000, 32'hFFFF_FFFE, 32'h1234_5678, 32'hA5A5_A5A5, 32'h8000_000F};
        mreset();
        do_reset();

        // R3: probes on every BAR.
        for (int i = 0; i < 6; i++) begin
            wr(4 + i, 4'hF, 32'hFFFF_FFFF);
            sweep("R3 probe");
        end
        // R4/R5/R6: patterns on every BAR.
        for (int p = 0; p < 5; p++)
            for (int i = 0; i < 6; i++) begin
                wr(4 + i, 4'hF, pats[p]);
                sweep("R5 pattern");
            end
        // R8: byte-wise all-ones never probes.
        for (int i = 0; i < 6; i++) begin
            wr(4 + i, 4'hF, 32'h0);
            for (int b = 0; b < 4; b++) wr(4 + i, 4'(1 << b), 32'hFFFF_FFFF);
            sweep("R8 bytewise");
        end
        wr(5, 4'b0000, 32'hDEAD_BEEF);
        sweep("R8 no bytes");
        // R7: ROM probe and near misses.
        wr(12, 4'hF, 32'hFFFF_F800); sweep("R7 probe");
        wr(12, 4'hF, 32'h1234_5FFF); sweep("R7 store");
        wr(12, 4'hF, 32'hFFFF_FFFF); sweep("R7 near miss");
        wr(12, 4'b0001, 32'h0000_0000); sweep("R7 byte disable");
        // R9: writable and read-only fields.
        wr(1, 4'hF, 32'hFFFF_0147); sweep("R9 command");
        wr(3, 4'b0010, 32'h0000_4000); sweep("R9 latency");
        wr(3, 4'hF, 32'hFFFF_FF10); sweep("R9 timing dword");
        wr(15, 4'hF, 32'hFFFF_FF0B); sweep("R9 int line");
        for (int a = 0; a < 64; a++)
            if (a == 0 || a == 2 || a == 11 || a == 13 || a == 10 || a == 14 || a >= 16)
                wr(a, 4'hF, 32'hFFFF_FFFF);
        sweep("R10 read-only and holes");
        // R1: reset after activity.
        do_reset();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule